// File: doc/BRIEF.md
# Four-Digit BCD Setpoint Editor

This block holds a phase setpoint in the range 00.00 to 90.00 as four BCD digits (tens, units, tenths, hundredths). A user changes it with three single-cycle button pulses: one that selects and advances, one that steps up and one that steps down. There are three edit positions. The tens digit and the units digit are stepped one at a time. The two fractional digits form one position that moves in steps of 0.05. While a position is selected, the block blanks its display digits on alternate blink half-periods, which it derives from a slow tick input.

The new value takes effect only when the advance press is given on the last position. At that press the setpoint is converted to a converter count with 0.05 per count, measured downward from the top of the range, and a single-cycle load strobe is raised. Debouncing, display multiplexing and the converter itself are outside this block.

Top module: `sp_setpoint_editor`

## Requirements
- R1: After reset the digits read 9,0,0,0 (90.00), `dac_code_o` is 0, `editing_o` and `blank_o` are low, and `dac_load_o` is high for exactly the first cycle after reset is released.
- R2: From idle, an advance press sets `editing_o` and selects the tens position. Each further advance press moves the selection from tens to units and from units to the fractional pair. An advance press on the fractional pair clears `editing_o`.
- R3: While tens or units is selected, an up press adds 1 and a down press subtracts 1. The digit wraps within 0..9 (9 up gives 0, 0 down gives 9) and never carries into another digit.
- R4: While the fractional pair is selected, each press moves the tenths/hundredths pair together by 0.05 through 00,05,...,95. Up from 95 gives 00 and down from 00 gives 95, with no carry. The hundredths digit is always 0 or 5.
- R5: A step whose result would be above 90.00 is ignored and leaves all four digits unchanged.
- R6: Step presses have no effect while `editing_o` is low. An up and a down press in the same cycle are both ignored. An advance press in the same cycle as a step press is acted on alone.
- R7: One clock after the final advance press, `dac_code_o` equals 1800 − (setpoint / 0.05). This gives 0 at 90.00 and 1800 at 00.00. `dac_load_o` is high for that one cycle. At no other time does `dac_code_o` change.
- R8: `blank_o` has bit 3 for tens, bit 2 for units, bit 1 for tenths and bit 0 for hundredths; a set bit darkens that digit. While editing, the selected position's bits are set during the dark half-period. For the fractional pair this means bits 1 and 0 together. The phase toggles every `BLINK_DIV` ticks and restarts lit on entry and on every selection move. Outside editing, `blank_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sel_press_i | input | 1 | Advance/select press, one-cycle pulse |
| inc_press_i | input | 1 | Step-up press, one-cycle pulse |
| dec_press_i | input | 1 | Step-down press, one-cycle pulse |
| blink_tick_i | input | 1 | Slow time base pulse for blinking |
| tens_o | output | 4 | Tens digit (BCD) |
| units_o | output | 4 | Units digit (BCD) |
| tenths_o | output | 4 | Tenths digit (BCD) |
| hundredths_o | output | 4 | Hundredths digit (BCD) |
| blank_o | output | 4 | Per-digit darken mask (bit 3 = tens) |
| dac_code_o | output | CODE_W | Converter count for the confirmed setpoint |
| dac_load_o | output | 1 | One-cycle load strobe |
| editing_o | output | 1 | High while a position is selected |

## Verification
The bench builds the editor with `MAX_WHOLE`=90, `FRAC_STEP`=5 and `CODE_W`=12, which gives the 1800-count scale, so the full-scale and zero-scale codes are checked exactly. It sets `BLINK_DIV` to 2 with blinking enabled, so two tick pulses are enough to reach a dark half-period and a second toggle. Both blink edges and the restart of the phase on a selection move therefore show up within a few cycles, on both the single-digit and the paired-digit masks.

// File: rtl/sp_pkg.sv
package sp_pkg;
   // Edit position currently selected; order is the advance sequence
   typedef enum logic [1:0] {
      POS_TENS  = 2'd0,
      POS_UNITS = 2'd1,
      POS_FRAC  = 2'd2
   } sp_pos_e;

   localparam int unsigned SP_NDIGITS = 4;
endpackage

// File: rtl/sp_blink_gen.sv
module sp_blink_gen #(
   parameter int unsigned BLINK_DIV = 25,
   parameter bit          BLINK_EN  = 1'b1
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic restart_i,
   input  logic tick_i,
   output logic dark_o
);
   localparam int unsigned CNT_W = (BLINK_DIV > 1) ? $clog2(BLINK_DIV) : 1;

   if (BLINK_DIV < 1) begin : g_bad_div
      $error("BLINK_DIV must be at least 1");
   end

   if (BLINK_EN) begin : g_blink
      logic [CNT_W-1:0] cnt_q;
      logic             dark_q;

      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            cnt_q  <= '0;
            dark_q <= 1'b0;
         end else if (restart_i) begin
            cnt_q  <= '0;
            dark_q <= 1'b0;
         end else if (tick_i) begin
            if (cnt_q == CNT_W'(BLINK_DIV - 1)) begin
               cnt_q  <= '0;
               dark_q <= ~dark_q;
            end else begin
               cnt_q <= cnt_q + 1'b1;
            end
         end
      end
      assign dark_o = dark_q;
   end else begin : g_steady
      logic unused_blink;
      assign unused_blink = ^{clk_i, rst_ni, restart_i, tick_i};
      assign dark_o = 1'b0;
   end
endmodule

// File: rtl/sp_digit_store.sv
module sp_digit_store
   import sp_pkg::*;
#(
   parameter int unsigned MAX_WHOLE = 90,
   parameter int unsigned FRAC_STEP = 5
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  sp_pos_e       pos_i,
   input  logic          up_i,
   input  logic          down_i,
   output logic [3:0]    tens_o,
   output logic [3:0]    units_o,
   output logic [$clog2(100/FRAC_STEP)-1:0] fidx_o,
   output logic [3:0]    tenths_o,
   output logic [3:0]    hundredths_o
);
   localparam int unsigned STEPS  = 100 / FRAC_STEP;
   localparam int unsigned FIDX_W = $clog2(STEPS);
   localparam int unsigned LIMIT  = MAX_WHOLE * 100;

   if (MAX_WHOLE > 99) begin : g_bad_max
      $error("MAX_WHOLE must fit in two digits");
   end
   if (FRAC_STEP == 0 || (100 % FRAC_STEP) != 0) begin : g_bad_step
      $error("FRAC_STEP must divide 100");
   end

   logic [3:0]        tens_q, units_q, tens_n, units_n;
   logic [FIDX_W-1:0] fidx_q, fidx_n;
   int unsigned       cand;
   int unsigned       frac_h;

   function automatic logic [3:0] wrap_digit(input logic [3:0] d, input logic up);
      if (up) return (d == 4'd9) ? 4'd0 : d + 4'd1;
      else    return (d == 4'd0) ? 4'd9 : d - 4'd1;
   endfunction

   always_comb begin
      tens_n  = tens_q;
      units_n = units_q;
      fidx_n  = fidx_q;
      unique case (pos_i)
         POS_TENS:  tens_n  = wrap_digit(tens_q, up_i);
         POS_UNITS: units_n = wrap_digit(units_q, up_i);
         default: begin
            if (up_i) fidx_n = (fidx_q == FIDX_W'(STEPS - 1)) ? '0 : fidx_q + 1'b1;
            else      fidx_n = (fidx_q == '0) ? FIDX_W'(STEPS - 1) : fidx_q - 1'b1;
         end
      endcase
      cand = 1000 * int'(tens_n) + 100 * int'(units_n) + FRAC_STEP * int'(fidx_n);
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         tens_q  <= 4'(MAX_WHOLE / 10);
         units_q <= 4'(MAX_WHOLE % 10);
         fidx_q  <= '0;
      end else if ((up_i ^ down_i) && (cand <= LIMIT)) begin
         tens_q  <= tens_n;
         units_q <= units_n;
         fidx_q  <= fidx_n;
      end
   end

   assign frac_h       = FRAC_STEP * int'(fidx_q);
   assign tens_o       = tens_q;
   assign units_o      = units_q;
   assign fidx_o       = fidx_q;
   assign tenths_o     = 4'(frac_h / 10);
   assign hundredths_o = 4'(frac_h % 10);
endmodule

// File: rtl/sp_code_map.sv
module sp_code_map #(
   parameter int unsigned MAX_WHOLE = 90,
   parameter int unsigned FRAC_STEP = 5,
   parameter int unsigned CODE_W    = 12
) (
   input  logic [3:0]                       tens_i,
   input  logic [3:0]                       units_i,
   input  logic [$clog2(100/FRAC_STEP)-1:0] fidx_i,
   output logic [CODE_W-1:0]                code_o
);
   localparam int unsigned STEPS      = 100 / FRAC_STEP;
   localparam int unsigned FULL_COUNT = MAX_WHOLE * STEPS;

   if (FULL_COUNT >= (1 << CODE_W)) begin : g_bad_width
      $error("CODE_W too narrow for full-scale count");
   end

   int unsigned count;

   always_comb begin
      count  = int'(tens_i) * (10 * STEPS) + int'(units_i) * STEPS + int'(fidx_i);
      code_o = CODE_W'(FULL_COUNT - count);
   end
endmodule

// File: rtl/sp_setpoint_editor.sv
module sp_setpoint_editor
   import sp_pkg::*;
#(
   parameter int unsigned MAX_WHOLE = 90,
   parameter int unsigned FRAC_STEP = 5,
   parameter int unsigned CODE_W    = 12,
   parameter int unsigned BLINK_DIV = 25,
   parameter bit          BLINK_EN  = 1'b1
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              sel_press_i,
   input  logic              inc_press_i,
   input  logic              dec_press_i,
   input  logic              blink_tick_i,
   output logic [3:0]        tens_o,
   output logic [3:0]        units_o,
   output logic [3:0]        tenths_o,
   output logic [3:0]        hundredths_o,
   output logic [SP_NDIGITS-1:0] blank_o,
   output logic [CODE_W-1:0] dac_code_o,
   output logic              dac_load_o,
   output logic              editing_o
);
   localparam int unsigned FIDX_W = $clog2(100 / FRAC_STEP);

   logic              editing_q, boot_q, load_q;
   sp_pos_e           pos_q;
   logic [CODE_W-1:0] code_q, code_new;
   logic [FIDX_W-1:0] fidx;
   logic              step_en, do_up, do_down, dark;
   logic [SP_NDIGITS-1:0] sel_mask;

   // A step acts only while editing, alone, and without an advance press
   assign step_en = editing_q & ~sel_press_i & (inc_press_i ^ dec_press_i);
   assign do_up   = step_en & inc_press_i;
   assign do_down = step_en & dec_press_i;

   sp_digit_store #(.MAX_WHOLE(MAX_WHOLE), .FRAC_STEP(FRAC_STEP)) i_store (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .pos_i        (pos_q),
      .up_i         (do_up),
      .down_i       (do_down),
      .tens_o       (tens_o),
      .units_o      (units_o),
      .fidx_o       (fidx),
      .tenths_o     (tenths_o),
      .hundredths_o (hundredths_o)
   );

   sp_code_map #(.MAX_WHOLE(MAX_WHOLE), .FRAC_STEP(FRAC_STEP), .CODE_W(CODE_W)) i_map (
      .tens_i  (tens_o),
      .units_i (units_o),
      .fidx_i  (fidx),
      .code_o  (code_new)
   );

   sp_blink_gen #(.BLINK_DIV(BLINK_DIV), .BLINK_EN(BLINK_EN)) i_blink (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .restart_i (sel_press_i),
      .tick_i    (blink_tick_i),
      .dark_o    (dark)
   );

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         editing_q <= 1'b0;
         pos_q     <= POS_TENS;
         boot_q    <= 1'b1;
         load_q    <= 1'b0;
         code_q    <= '0;
      end else begin
         boot_q <= 1'b0;
         load_q <= boot_q;
         if (sel_press_i) begin
            if (!editing_q) begin
               editing_q <= 1'b1;
               pos_q     <= POS_TENS;
            end else begin
               unique case (pos_q)
                  POS_TENS:  pos_q <= POS_UNITS;
                  POS_UNITS: pos_q <= POS_FRAC;
                  default: begin
                     pos_q     <= POS_TENS;
                     editing_q <= 1'b0;
                     code_q    <= code_new;
                     load_q    <= 1'b1;
                  end
               endcase
            end
         end
      end
   end

   always_comb begin
      unique case (pos_q)
         POS_TENS:  sel_mask = 4'b1000;
         POS_UNITS: sel_mask = 4'b0100;
         default:   sel_mask = 4'b0011;
      endcase
   end

   assign blank_o    = (editing_q && dark) ? sel_mask : '0;
   assign dac_code_o = code_q;
   assign dac_load_o = load_q;
   assign editing_o  = editing_q;
endmodule

// File: rtl/sp_setpoint_editor_chk.sv
module sp_setpoint_editor_chk #(
   parameter int unsigned MAX_WHOLE = 90,
   parameter int unsigned CODE_W    = 12
) (
   input logic              clk_i,
   input logic              rst_ni,
   input logic              sel_press_i,
   input logic [3:0]        tens_o,
   input logic [3:0]        units_o,
   input logic [3:0]        tenths_o,
   input logic [3:0]        hundredths_o,
   input logic [3:0]        blank_o,
   input logic [CODE_W-1:0] dac_code_o,
   input logic              dac_load_o,
   input logic              editing_o
);
   int unsigned value;
   assign value = 1000 * int'(tens_o) + 100 * int'(units_o)
                + 10 * int'(tenths_o) + int'(hundredths_o);

   // R2
   enter_on_press_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(editing_o) |-> $past(sel_press_i));

   // R5
   within_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      value <= MAX_WHOLE * 100);

   // R4
   digit_legal_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      tens_o <= 4'd9 && units_o <= 4'd9 && tenths_o <= 4'd9 && hundredths_o <= 4'd9);

   // R6
   idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!editing_o && !$past(editing_o)) |->
      ($stable(tens_o) && $stable(units_o) && $stable(tenths_o) && $stable(hundredths_o)));

   // R7
   load_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      dac_load_o |=> !dac_load_o);

   // R7
   finish_loads_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(editing_o) |-> dac_load_o);

   // R7
   code_moves_with_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !$stable(dac_code_o) |-> dac_load_o);

   // R8
   idle_lit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !editing_o |-> (blank_o == 4'b0000));

   // R8
   mask_width_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $countones(blank_o) <= 2);
endmodule

bind sp_setpoint_editor sp_setpoint_editor_chk #(
   .MAX_WHOLE (MAX_WHOLE),
   .CODE_W    (CODE_W)
) i_chk (
   .clk_i        (clk_i),
   .rst_ni       (rst_ni),
   .sel_press_i  (sel_press_i),
   .tens_o       (tens_o),
   .units_o      (units_o),
   .tenths_o     (tenths_o),
   .hundredths_o (hundredths_o),
   .blank_o      (blank_o),
   .dac_code_o   (dac_code_o),
   .dac_load_o   (dac_load_o),
   .editing_o    (editing_o)
);

// File: tb/test_sp_setpoint_editor.sv
`timescale 1ns/1ps
module test_sp_setpoint_editor;
   localparam int CODE_W = 12;

   logic clk = 1'b0;
   logic rst_ni = 1'b0;
   logic sel_press, inc_press, dec_press, tick;
   logic [3:0] tens, units, tenths, hund, blank;
   logic [CODE_W-1:0] code;
   logic load, editing;

   int n_checks = 0;
   int n_fail   = 0;

   always #2 clk = ~clk;

   sp_setpoint_editor #(
      .MAX_WHOLE(90), .FRAC_STEP(5), .CODE_W(CODE_W), .BLINK_DIV(2), .BLINK_EN(1'b1)
   ) i_sp_setpoint_editor (
      .clk_i(clk), .rst_ni(rst_ni),
      .sel_press_i(sel_press), .inc_press_i(inc_press), .dec_press_i(dec_press),
      .blink_tick_i(tick),
      .tens_o(tens), .units_o(units), .tenths_o(tenths), .hundredths_o(hund),
      .blank_o(blank), .dac_code_o(code), .dac_load_o(load), .editing_o(editing)
   );

   // op: 0 advance, 1 up, 2 down; then tens, units, tenths, hundredths, editing
   localparam int NV = 15;
   localparam logic [18:0] VEC [NV] = '{
      {2'd1, 4'd9, 4'd0, 4'd0, 4'd0, 1'b0},  // R6 idle step ignored
      {2'd0, 4'd9, 4'd0, 4'd0, 4'd0, 1'b1},  // R2 enter, tens
      {2'd1, 4'd0, 4'd0, 4'd0, 4'd0, 1'b1},  // R3 9 up wraps to 0
      {2'd2, 4'd9, 4'd0, 4'd0, 4'd0, 1'b1},  // R3 0 down wraps to 9
      {2'd2, 4'd8, 4'd0, 4'd0, 4'd0, 1'b1},  // R3
      {2'd0, 4'd8, 4'd0, 4'd0, 4'd0, 1'b1},  // R2 units
      {2'd2, 4'd8, 4'd9, 4'd0, 4'd0, 1'b1},  // R3 units wrap down
      {2'd1, 4'd8, 4'd0, 4'd0, 4'd0, 1'b1},  // R3 units wrap up
      {2'd1, 4'd8, 4'd1, 4'd0, 4'd0, 1'b1},  // R3
      {2'd0, 4'd8, 4'd1, 4'd0, 4'd0, 1'b1},  // R2 fraction
      {2'd2, 4'd8, 4'd1, 4'd9, 4'd5, 1'b1},  // R4 00 down to 95
      {2'd1, 4'd8, 4'd1, 4'd0, 4'd0, 1'b1},  // R4 95 up to 00
      {2'd1, 4'd8, 4'd1, 4'd0, 4'd5, 1'b1},  // R4
      {2'd1, 4'd8, 4'd1, 4'd1, 4'd0, 1'b1},  // R4
      {2'd0, 4'd8, 4'd1, 4'd1, 4'd0, 1'b0}   // R2 finish
   };

   function automatic string vec_req(input int i);
      case (i)
         0:       return "R6";
         1, 5, 9, 14: return "R2";
         10, 11, 12, 13: return "R4";
         default: return "R3";
      endcase
   endfunction

   function automatic int exp_code(input int t, input int u, input int d3, input int d4);
      return 1800 - (t * 200 + u * 20 + (d3 * 10 + d4) / 5);
   endfunction

   task automatic check(input string req, input string what, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic check_digits(input string req, input int t, input int u, input int d3, input int d4);
      check(req, "digits", 1000*int'(tens) + 100*int'(units) + 10*int'(tenths) + int'(hund),
            1000*t + 100*u + 10*d3 + d4);
   endtask

   // Drive pulses for one cycle; return at the negedge after the capturing edge
   task automatic press(input logic s, input logic up, input logic dn);
      @(negedge clk);
      sel_press = s; inc_press = up; dec_press = dn;
      @(negedge clk);
      sel_press = 1'b0; inc_press = 1'b0; dec_press = 1'b0;
   endtask

   task automatic pulse_tick();
      @(negedge clk);
      tick = 1'b1;
      @(negedge clk);
      tick = 1'b0;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_ni = 1'b0;
      repeat (2) @(negedge clk);
      rst_ni = 1'b1;
      @(negedge clk);
      // R1 state in the first cycle after release
      check_digits("R1", 9, 0, 0, 0);
      check("R1", "code", int'(code), 0);
      check("R1", "editing", int'(editing), 0);
      check("R1", "blank", int'(blank), 0);
      check("R1", "boot load", int'(load), 1);
      @(negedge clk);
      check("R1", "load one cycle", int'(load), 0);
   endtask

   initial begin
      #(4 * 20000);
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
   end

   initial begin
      sel_press = 1'b0; inc_press = 1'b0; dec_press = 1'b0; tick = 1'b0;
      do_reset();

      for (int i = 0; i < NV; i++) begin
         logic [18:0] v;
         v = VEC[i];
         press(v[18:17] == 2'd0, v[18:17] == 2'd1, v[18:17] == 2'd2);
         check_digits(vec_req(i), int'(v[16:13]), int'(v[12:9]), int'(v[8:5]), int'(v[4:1]));
         check(vec_req(i), "editing", int'(editing), int'(v[0]));
      end
      // R7 confirmed 81.10
      check("R7", "code 81.10", int'(code), exp_code(8, 1, 1, 0));
      check("R7", "load", int'(load), 1);
      @(negedge clk);
      check("R7", "load drops", int'(load), 0);
      check("R7", "code held", int'(code), 178);

      // R6 simultaneous presses
      press(1, 0, 0);
      press(0, 1, 1);
      check_digits("R6", 8, 1, 1, 0);
      press(1, 1, 0);
      check_digits("R6", 8, 1, 1, 0);
      press(0, 1, 0);                       // units now selected
      check_digits("R6", 8, 2, 1, 0);
      check("R7", "code not yet updated", int'(code), 178);
      press(1, 0, 0);
      press(1, 0, 0);
      check("R7", "code 82.10", int'(code), exp_code(8, 2, 1, 0));

      // R8 blink
      press(1, 0, 0);
      check("R8", "lit on entry", int'(blank), 0);
      pulse_tick();
      check("R8", "one tick lit", int'(blank), 0);
      pulse_tick();
      check("R8", "tens dark", int'(blank), 8);
      press(1, 0, 0);
      check("R8", "restart on move", int'(blank), 0);
      press(1, 0, 0);
      pulse_tick();
      pulse_tick();
      check("R8", "fraction dark", int'(blank), 3);
      pulse_tick();
      pulse_tick();
      check("R8", "fraction lit again", int'(blank), 0);
      press(1, 0, 0);
      check("R8", "idle blank", int'(blank), 0);

      // R5 limits at 90.00
      do_reset();
      press(1, 0, 0);
      press(0, 1, 0);                       // tens 9 -> 0 legal
      press(0, 0, 1);                       // back to 9
      press(1, 0, 0);
      press(0, 1, 0);                       // 91.00 refused
      check_digits("R5", 9, 0, 0, 0);
      press(1, 0, 0);
      press(0, 0, 1);                       // 90.95 refused
      check_digits("R5", 9, 0, 0, 0);
      press(0, 1, 0);                       // 90.05 refused
      check_digits("R5", 9, 0, 0, 0);
      press(1, 0, 0);
      check("R7", "code 90.00", int'(code), 0);
      check("R7", "load at 90.00", int'(load), 1);

      // R7 full scale at 00.00
      press(1, 0, 0);
      press(0, 1, 0);
      press(1, 0, 0);
      press(1, 0, 0);
      press(0, 0, 1);
      check_digits("R4", 0, 0, 9, 5);
      press(0, 1, 0);
      check_digits("R4", 0, 0, 0, 0);
      press(1, 0, 0);
      check("R7", "code 00.00", int'(code), 1800);

      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
   end
endmodule